// File: doc/BRIEF.md
# Pairable Buffered Pulse Accumulator Bank

This block counts qualified edges on four pulse lines that arrive already synchronized to the block clock. Each line feeds its own 8-bit accumulator. A per-line select bit chooses whether rising or falling transitions are counted. Each accumulator stops at its maximum value and raises a sticky overflow flag when another edge arrives at that maximum.

Two adjacent accumulators can be joined at run time into one 16-bit counter. In that mode the even-numbered channel is the low byte and the odd-numbered channel is the high byte. Only the even channel's line is counted, and the low byte's carry advances the high byte.

A single latch strobe starts a new measurement window. On one clock edge it copies every live count and every live flag into holding registers, and it clears the live state. All counts, holding values and flags are read back through a small combinational register port.

Top module: `pacc_bank`

## Requirements
- R1: After reset, every live count, held count, live flag and held flag reads as zero.
- R2: A channel with `rise_sel_i` bit = 1 counts a low-to-high change between two consecutive sampled cycles. A channel with the bit = 0 counts a high-to-low change. Each qualified edge adds exactly one, and the new value can be read in the cycle after the clock edge that sampled the changed level.
- R3: An unpaired channel at 0xFF ignores further edges and keeps 0xFF. It sets its live flag, bit c of the live-flag register.
- R4: With `pair_i[p]` = 1, channels 2p (low byte) and 2p+1 (high byte) form one 16-bit counter. Edges on line 2p+1 have no effect on either byte.
- R5: In a joined pair, an edge on line 2p with the low byte at 0xFF and the high byte below 0xFF sets the low byte to 0x00 and adds one to the high byte.
- R6: A joined pair at 0xFFFF keeps 0xFFFF on further edges and sets live flag bit 2p+1. Live flag bit 2p is not set by this event.
- R7: On a clock edge where `latch_i` is high, each held count takes that channel's live count and each held flag takes its live flag. On the same edge every live count and live flag is cleared.
- R8: An edge that coincides with the latch strobe counts as the first edge of the new window. The live low byte or unpaired channel becomes 1, and a joined high byte becomes 0.
- R9: A live flag stays set until the next latch strobe, regardless of further edges or pairing changes.
- R10: Register map read on `rd_data_o` for address `rd_addr_i`:
  - 0 to 3: live counts of channels 0 to 3.
  - 4 to 7: held counts of channels 0 to 3.
  - 8: live flags in bits 3:0.
  - 9: held flags in bits 3:0.
  - Any other address, and bits 7:4 of addresses 8 and 9, read as zero.
- R11: Changing `pair_i` does not by itself alter any stored count or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 4 | Synchronized pulse lines, one per channel |
| rise_sel_i | input | 4 | Per-channel edge select, 1 = rising, 0 = falling |
| pair_i | input | 2 | Per-pair join enable, bit p joins channels 2p and 2p+1 |
| latch_i | input | 1 | Snapshot-and-clear strobe |
| rd_addr_i | input | 4 | Register port address |
| rd_data_o | output | 8 | Register port read data |

## Verification
The bench drives counts to the boundaries and checks each one:
- Unpaired channels are taken to exactly 0xFF. A design that wraps instead of saturating reads back 0x00 with no flag.
- A joined pair is carried across the byte boundary. A design that ignores the carry leaves the high byte unchanged, and one that still counts the odd line adds spurious edges to the pair.
- A pair is taken to 0xFFFF by building both bytes unpaired and then joining them. This also shows that joining at run time keeps the stored counts, and that the overflow lands on the high flag only.
- The latch strobe is fired both alone and together with an edge. A design that loses the coincident edge, or that puts it into the held value, reads back the wrong live or held count.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

  // per-slice control produced by the pairing logic
  typedef struct packed {
    logic step;  // advance request
    logic wrap;  // at max: wrap to zero instead of saturating
    logic seed;  // value of the first count of a new window
  } slice_ctl_t;

endpackage

// File: rtl/pacc_edge.sv
module pacc_edge #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] line_i,
  input  logic [NUM_CH-1:0] rise_sel_i,
  output logic [NUM_CH-1:0] hit_o
);

  logic [NUM_CH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= line_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_det
    assign hit_o[c] = rise_sel_i[c] ? (line_i[c] & ~prev_q[c])
                                    : (~line_i[c] & prev_q[c]);
  end

endmodule

// File: rtl/pacc_slice.sv
module pacc_slice
  import pacc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latch_i,
  input  slice_ctl_t       ctl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] hold_o,
  output logic             hold_ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, hold_q;
  logic             ovf_q, hold_ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      hold_q     <= '0;
      ovf_q      <= 1'b0;
      hold_ovf_q <= 1'b0;
    end else if (latch_i) begin
      hold_q     <= cnt_q;
      hold_ovf_q <= ovf_q;
      cnt_q      <= CNT_W'(ctl_i.seed);
      ovf_q      <= 1'b0;
    end else if (ctl_i.step) begin
      if (cnt_q == CNT_MAX) begin
        if (ctl_i.wrap) cnt_q <= '0;
        else            ovf_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign full_o     = (cnt_q == CNT_MAX);
  assign ovf_o      = ovf_q;
  assign hold_o     = hold_q;
  assign hold_ovf_o = hold_ovf_q;

endmodule

// File: rtl/pacc_link.sv
module pacc_link
  import pacc_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned NUM_PAIR = NUM_CH / 2
) (
  input  logic [NUM_CH-1:0]   hit_i,
  input  logic [NUM_CH-1:0]   full_i,
  input  logic [NUM_PAIR-1:0] pair_i,
  output slice_ctl_t          ctl_o [NUM_CH]
);

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    localparam int unsigned LO = 2 * p;
    localparam int unsigned HI = 2 * p + 1;

    always_comb begin
      if (pair_i[p]) begin
        // low byte holds at 0xFFFF so the overflow lands on the high slice
        ctl_o[LO].step = hit_i[LO] & ~(full_i[LO] & full_i[HI]);
        ctl_o[LO].wrap = 1'b1;
        ctl_o[LO].seed = hit_i[LO];
        ctl_o[HI].step = hit_i[LO] & full_i[LO];
        ctl_o[HI].wrap = 1'b0;
        ctl_o[HI].seed = 1'b0;
      end else begin
        ctl_o[LO].step = hit_i[LO];
        ctl_o[LO].wrap = 1'b0;
        ctl_o[LO].seed = hit_i[LO];
        ctl_o[HI].step = hit_i[HI];
        ctl_o[HI].wrap = 1'b0;
        ctl_o[HI].seed = hit_i[HI];
      end
    end
  end

endmodule

// File: rtl/pacc_regmux.sv
module pacc_regmux #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]             rd_addr_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  live_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  hold_i,
  input  logic [NUM_CH-1:0]             ovf_i,
  input  logic [NUM_CH-1:0]             hold_ovf_i,
  output logic [CNT_W-1:0]              rd_data_o
);

  localparam logic [ADDR_W-1:0] ADDR_OVF  = ADDR_W'(2 * NUM_CH);
  localparam logic [ADDR_W-1:0] ADDR_HOVF = ADDR_W'(2 * NUM_CH + 1);

  always_comb begin
    rd_data_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr_i == ADDR_W'(c))          rd_data_o = live_i[c];
      if (rd_addr_i == ADDR_W'(c + NUM_CH)) rd_data_o = hold_i[c];
    end
    if (rd_addr_i == ADDR_OVF)  rd_data_o = CNT_W'(ovf_i);
    if (rd_addr_i == ADDR_HOVF) rd_data_o = CNT_W'(hold_ovf_i);
  end

endmodule

// File: rtl/pacc_bank.sv
module pacc_bank
  import pacc_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned NUM_PAIR = NUM_CH / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CH-1:0]   line_i,
  input  logic [NUM_CH-1:0]   rise_sel_i,
  input  logic [NUM_PAIR-1:0] pair_i,
  input  logic                latch_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [CNT_W-1:0]    rd_data_o
);

  logic [NUM_CH-1:0]            hit;
  logic [NUM_CH-1:0]            full;
  logic [NUM_CH-1:0]            ovf_live;
  logic [NUM_CH-1:0]            ovf_hold;
  logic [NUM_CH-1:0][CNT_W-1:0] live_cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] hold_cnt;
  slice_ctl_t                   ctl [NUM_CH];

  pacc_edge #(.NUM_CH(NUM_CH)) i_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_i),
    .rise_sel_i (rise_sel_i),
    .hit_o      (hit)
  );

  pacc_link #(.NUM_CH(NUM_CH)) i_link (
    .hit_i  (hit),
    .full_i (full),
    .pair_i (pair_i),
    .ctl_o  (ctl)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slice
    pacc_slice #(.CNT_W(CNT_W)) i_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .latch_i    (latch_i),
      .ctl_i      (ctl[c]),
      .cnt_o      (live_cnt[c]),
      .full_o     (full[c]),
      .ovf_o      (ovf_live[c]),
      .hold_o     (hold_cnt[c]),
      .hold_ovf_o (ovf_hold[c])
    );
  end

  pacc_regmux #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) i_regmux (
    .rd_addr_i  (rd_addr_i),
    .live_i     (live_cnt),
    .hold_i     (hold_cnt),
    .ovf_i      (ovf_live),
    .hold_ovf_i (ovf_hold),
    .rd_data_o  (rd_data_o)
  );

endmodule

// File: rtl/pacc_bank_chk.sv
module pacc_bank_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned NUM_PAIR = NUM_CH / 2
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           latch_i,
  input logic [NUM_PAIR-1:0]            pair_i,
  input logic [NUM_CH-1:0][CNT_W-1:0]   live_i,
  input logic [NUM_CH-1:0][CNT_W-1:0]   hold_i,
  input logic [NUM_CH-1:0]              ovf_i,
  input logic [NUM_CH-1:0]              hold_ovf_i
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R7
  hold_snap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> (hold_i == $past(live_i)) && (hold_ovf_i == $past(ovf_i)));

  // R7
  live_flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> (ovf_i == '0));

  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> ((ovf_i & $past(ovf_i)) == $past(ovf_i)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R8
    seed_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      latch_i |=> (live_i[c] <= CNT_W'(1)));

    // R3
    sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!latch_i && !pair_i[c/2] && live_i[c] == CNT_MAX) |=> (live_i[c] == CNT_MAX));
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pr
    // R4
    hi_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pair_i[p] && !latch_i && live_i[2*p] != CNT_MAX) |=> $stable(live_i[2*p+1]));

    // R6
    lo_flag_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pair_i[p] && !latch_i && !ovf_i[2*p]) |=> !ovf_i[2*p]);
  end

endmodule

bind pacc_bank pacc_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .latch_i    (latch_i),
  .pair_i     (pair_i),
  .live_i     (live_cnt),
  .hold_i     (hold_cnt),
  .ovf_i      (ovf_live),
  .hold_ovf_i (ovf_hold)
);

// File: tb/test_pacc_bank.sv
`timescale 1ns/1ps
module test_pacc_bank;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] line = '0;
  logic [3:0] rise_sel = '0;
  logic [1:0] pair = '0;
  logic       latch = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;

  always #4 clk = ~clk;

  pacc_bank i_pacc_bank (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .line_i     (line),
    .rise_sel_i (rise_sel),
    .pair_i     (pair),
    .latch_i    (latch),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data)
  );

  typedef struct {
    logic [3:0] addr;
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model, built from the requirements
  int m_live[4];
  int m_hold[4];
  bit m_ovf[4];
  bit m_hovf[4];
  bit [1:0] m_pair = '0;

  function automatic void model_edge(int c);
    int p = c / 2;
    if (m_pair[p]) begin
      int lo = 2 * p;
      int hi = 2 * p + 1;
      if (c == hi) return;  // R4
      if (m_live[lo] == 255 && m_live[hi] == 255) m_ovf[hi] = 1'b1;  // R6
      else if (m_live[lo] == 255) begin m_live[lo] = 0; m_live[hi]++; end  // R5
      else m_live[lo]++;
    end else begin
      if (m_live[c] == 255) m_ovf[c] = 1'b1;  // R3
      else m_live[c]++;
    end
  endfunction

  function automatic void model_latch(bit [3:0] mask);
    for (int c = 0; c < 4; c++) begin
      m_hold[c] = m_live[c];
      m_hovf[c] = m_ovf[c];
      m_live[c] = 0;
      m_ovf[c]  = 1'b0;
    end
    for (int c = 0; c < 4; c++)
      if (mask[c] && rise_sel[c]) model_edge(c);
  endfunction

  // monitor: pops one expectation per cycle
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (rd_data !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%0d actual=%02h expected=%02h", it.tag, it.addr, rd_data, it.exp);
      end
    end
  end

  task automatic sb_push(logic [3:0] a, logic [7:0] e, string tag);
    sb_item_t it;
    @(posedge clk); #1;
    rd_addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic check_all(string tag);
    logic [7:0] f, hf;
    f = '0; hf = '0;
    for (int c = 0; c < 4; c++) begin
      f[c]  = m_ovf[c];
      hf[c] = m_hovf[c];
    end
    for (int c = 0; c < 4; c++) sb_push(4'(c), 8'(m_live[c]), tag);
    for (int c = 0; c < 4; c++) sb_push(4'(c + 4), 8'(m_hold[c]), tag);
    sb_push(4'd8, f, tag);
    sb_push(4'd9, hf, tag);
    sb_push(4'd10, 8'h00, "R10");
    sb_push(4'd15, 8'h00, "R10");
  endtask

  // one high cycle then low: rising channels count on the first, falling on the second
  task automatic pulse(bit [3:0] mask);
    @(posedge clk); #1;
    line = mask;
    for (int c = 0; c < 4; c++) if (mask[c] && rise_sel[c]) model_edge(c);
    @(posedge clk); #1;
    line = '0;
    for (int c = 0; c < 4; c++) if (mask[c] && !rise_sel[c]) model_edge(c);
  endtask

  task automatic do_latch(bit [3:0] mask);
    @(posedge clk); #1;
    latch = 1'b1;
    line  = mask;
    model_latch(mask);
    @(posedge clk); #1;
    latch = 1'b0;
    line  = '0;
    for (int c = 0; c < 4; c++) if (mask[c] && !rise_sel[c]) model_edge(c);
  endtask

  task automatic set_pair(bit [1:0] v);
    @(posedge clk); #1;
    pair   = v;
    m_pair = v;
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_live[c] = 0; m_hold[c] = 0; m_ovf[c] = 0; m_hovf[c] = 0;
    end
    rise_sel = 4'b0101;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    check_all("R1");

    repeat (3) pulse(4'hF);
    check_all("R2");

    do_latch(4'b0000);
    check_all("R7");

    do_latch(4'b0001);
    check_all("R8");

    repeat (255) pulse(4'b0101);
    check_all("R3");
    pulse(4'b0100);
    check_all("R3");

    repeat (18) pulse(4'b0010);
    check_all("R9");

    set_pair(2'b01);
    check_all("R11");
    pulse(4'b0010);
    check_all("R4");
    pulse(4'b0001);
    check_all("R5");

    set_pair(2'b11);
    pulse(4'b0100);
    check_all("R5");

    do_latch(4'b0000);
    check_all("R7");

    set_pair(2'b00);
    repeat (255) pulse(4'b0011);
    set_pair(2'b01);
    check_all("R11");
    pulse(4'b0001);
    check_all("R6");
    pulse(4'b0011);
    check_all("R6");

    do_latch(4'b0001);
    check_all("R8");

    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule